// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the bus-facing register layer of a prioritized interrupt controller. A requester presents a 32-bit-aligned word address, a read/write flag, four byte-lane enables and write data for one cycle; one cycle later the block answers with a response flag, read data and an error flag. Behind the addresses sit a configuration word, an acknowledge word, an end-of-interrupt word, byte-wide software-set/clear registers and byte-wide priority registers.

The configuration word selects hardware or software vector mode and chooses a vector-table entry size of four or eight bytes. Reading the acknowledge word returns a table base in its high bits merged with the current vector number, shifted left by two or three places according to the entry size. Reading the acknowledge word or writing the end-of-interrupt word raises a one-cycle strobe toward the priority logic, which lies outside this block together with the nesting stack and the processor handshake. The size of an access never changes what it does. Accesses with an unsupported lane pattern or to an unmapped word are refused.

Top module: `intc_regif`

## Requirements
- R1: Lane enable bit k covers data bits [8k+7:8k]. Only these patterns are accepted: 0001, 0010, 0100, 1000, 0011, 0110, 1100, 1111. Any other pattern, including 0000, gives an error response, changes no register and raises no strobe.
- R2: Every request is answered in the next cycle with rsp_valid high for exactly that cycle. rdata is zero for writes and for refused accesses.
- R3: Word map: 0 configuration, 1 acknowledge, 2 end-of-interrupt, 3–4 software-set/clear, 5–8 priority. Byte register i sits in word base+i/4, lane i%4. Any other word address gives an error response with no side effect.
- R4: Configuration bit 0 is the hardware-vector enable (1 = hardware vector mode, 0 = software) and bit 5 is the entry size (1 = eight-byte entries). Both drive outputs. Every other bit reads 0 and ignores writes.
- R5: An acknowledge read returns the stored base in bits 31:12, ORed with cur_vec shifted left by 3 when the entry size is 1, or by 2 when it is 0. This holds in either vector mode.
- R6: Any accepted read of the acknowledge word raises ack_pulse for exactly the response cycle, whatever its lanes. An accepted write stores base bits 31:12 from the enabled lanes and raises no strobe.
- R7: Any accepted write to the end-of-interrupt word raises eoi_pulse for exactly the response cycle, whatever its lanes. A read of it returns 0 and raises no strobe.
- R8: A write to a software-set/clear byte sets its flag when data bit 1 is 1. Otherwise it clears the flag when data bit 0 is 1. Set wins over clear. A read returns the flag in bit 0 with the other bits 0. Bytes whose lanes are off are unchanged.
- R9: A priority byte stores data bits 3:0, reads back with bits 7:4 zero, and is driven on pri_flat[4i+3:4i].
- R10: After reset all registers, flags, priorities, strobes and response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Word address |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| cur_vec | input | 9 | Vector number from the priority logic |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Request refused |
| rdata | output | 32 | Read data |
| ack_pulse | output | 1 | Acknowledge strobe |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| hw_vec_mode | output | 1 | Hardware vector mode selected |
| vec_entry8 | output | 1 | Eight-byte vector entries selected |
| sw_pend | output | 8 | Software interrupt flags |
| pri_flat | output | 64 | Priorities, four bits per source |

## Verification
The bench aims at access size as a hidden variable. It reads the acknowledge word and writes the end-of-interrupt word with byte, middle-halfword and full-word lane patterns. A design that gated the strobes on size would drop or double a pulse there. It sweeps the refused lane patterns and unmapped words across every register class. A design that let such an access leak would change a flag, a priority or the mode, or fire a strobe. It flips the entry size between acknowledge reads of the largest vector number. Here a wrong shift would either bleed vector bits into the base or lose the top vector bit.

// File: rtl/intc_regif.sv
module intc_regif #(
  parameter int ADDR_W = 6,
  parameter int VEC_W  = 9,
  parameter int NSW    = 8,
  parameter int NPRI   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  input  logic [VEC_W-1:0]     cur_vec,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rdata,
  output logic                 ack_pulse,
  output logic                 eoi_pulse,
  output logic                 hw_vec_mode,
  output logic                 vec_entry8,
  output logic [NSW-1:0]       sw_pend,
  output logic [NPRI*4-1:0]    pri_flat
);
  localparam int SSC_WORDS = (NSW + 3) / 4;
  localparam int PRI_WORDS = (NPRI + 3) / 4;
  localparam int SSC_BASE  = 3;
  localparam int PRI_BASE  = SSC_BASE + SSC_WORDS;
  localparam int MAP_END   = PRI_BASE + PRI_WORDS;
  localparam int BASE_LO   = VEC_W + 3;

  logic lane_ok, mapped, ok, wr, rd;
  logic sel_cfg, sel_ack, sel_eoi;
  logic hven_q, vtes_q;
  logic [31:BASE_LO] base_q;
  logic sw_q [NSW];
  logic [3:0] pri_q [NPRI];
  logic [SSC_WORDS*32-1:0] ssc_rd;
  logic [PRI_WORDS*32-1:0] pri_rd;
  logic [31:0] vec_sh, ack_word, rd_word;

  always_comb begin
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b0110, 4'b1100, 4'b1111: lane_ok = 1'b1;
      default:                            lane_ok = 1'b0;
    endcase
  end

  assign sel_cfg = (addr == ADDR_W'(0));
  assign sel_ack = (addr == ADDR_W'(1));
  assign sel_eoi = (addr == ADDR_W'(2));
  assign mapped  = (int'(addr) < MAP_END);
  assign ok      = req && lane_ok && mapped;
  assign wr      = ok && we;
  assign rd      = ok && !we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hven_q <= 1'b0;
      vtes_q <= 1'b0;
      base_q <= '0;
    end else if (wr) begin
      if (sel_cfg && be[0]) begin
        hven_q <= wdata[0];
        vtes_q <= wdata[5];
      end
      if (sel_ack)
        for (int b = BASE_LO; b < 32; b++)
          if (be[b/8]) base_q[b] <= wdata[b];
    end
  end

  for (genvar i = 0; i < NSW; i++) begin : g_ssc
    localparam int W = SSC_BASE + i / 4;
    localparam int L = i % 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_q[i] <= 1'b0;
      else if (wr && addr == ADDR_W'(W) && be[L]) begin
        if (wdata[8*L+1])      sw_q[i] <= 1'b1;
        else if (wdata[8*L])   sw_q[i] <= 1'b0;
      end
    end
    assign sw_pend[i]       = sw_q[i];
    assign ssc_rd[8*i +: 8] = {7'b0, sw_q[i]};
  end
  for (genvar i = NSW; i < SSC_WORDS*4; i++) begin : g_ssc_pad
    assign ssc_rd[8*i +: 8] = 8'b0;
  end

  for (genvar i = 0; i < NPRI; i++) begin : g_pri
    localparam int W = PRI_BASE + i / 4;
    localparam int L = i % 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pri_q[i] <= 4'b0;
      else if (wr && addr == ADDR_W'(W) && be[L]) pri_q[i] <= wdata[8*L +: 4];
    end
    assign pri_flat[4*i +: 4] = pri_q[i];
    assign pri_rd[8*i +: 8]   = {4'b0, pri_q[i]};
  end
  for (genvar i = NPRI; i < PRI_WORDS*4; i++) begin : g_pri_pad
    assign pri_rd[8*i +: 8] = 8'b0;
  end

  assign vec_sh   = vtes_q ? (32'(cur_vec) << 3) : (32'(cur_vec) << 2);
  assign ack_word = {base_q, BASE_LO'(0)} | vec_sh;

  always_comb begin
    rd_word = '0;
    if (sel_cfg) rd_word = {26'b0, vtes_q, 4'b0, hven_q};
    if (sel_ack) rd_word = ack_word;
    for (int w = 0; w < SSC_WORDS; w++)
      if (addr == ADDR_W'(SSC_BASE + w)) rd_word = ssc_rd[32*w +: 32];
    for (int w = 0; w < PRI_WORDS; w++)
      if (addr == ADDR_W'(PRI_BASE + w)) rd_word = pri_rd[32*w +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rdata     <= '0;
      ack_pulse <= 1'b0;
      eoi_pulse <= 1'b0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && !ok;
      rdata     <= rd ? rd_word : 32'b0;
      ack_pulse <= rd && sel_ack;
      eoi_pulse <= wr && sel_eoi;
    end
  end

  assign hw_vec_mode = hven_q;
  assign vec_entry8  = vtes_q;

  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !ack_pulse && !eoi_pulse && $stable(hw_vec_mode) &&
                $stable(vec_entry8) && $stable(sw_pend) && $stable(pri_flat));

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req));

  p_ack_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> rsp_valid && !rsp_err && $past(!we) && !eoi_pulse);

  p_eoi_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> rsp_valid && !rsp_err && $past(we) && rdata == 32'b0);

  p_cfg_spare_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req && !we && addr == ADDR_W'(0))) |->
      (rdata & ~32'h0000_0021) == 32'b0);
endmodule

// File: tb/tb_intc_regif.sv
module tb_intc_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [8:0] cur_vec = '0;
  logic rsp_valid, rsp_err, ack_pulse, eoi_pulse, hw_vec_mode, vec_entry8;
  logic [31:0] rdata;
  logic [7:0] sw_pend;
  logic [63:0] pri_flat;

  intc_regif dut (.clk, .rst_n, .req, .we, .addr, .be, .wdata, .cur_vec,
    .rsp_valid, .rsp_err, .rdata, .ack_pulse, .eoi_pulse, .hw_vec_mode,
    .vec_entry8, .sw_pend, .pri_flat);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit m_hven = 0, m_vtes = 0;
  logic [31:0] m_base = '0;
  bit m_sw [8];
  logic [3:0] m_pri [16];

  logic e_valid = 0, e_err = 0, e_ack = 0, e_eoi = 0;
  logic [31:0] e_rdata = '0;

  function automatic bit legal_lanes(logic [3:0] b);
    return b inside {4'b1111, 4'b0110, 4'b0011, 4'b1100,
                     4'b0001, 4'b0010, 4'b0100, 4'b1000};
  endfunction

  function automatic logic [31:0] model_read(int a, logic [8:0] v);
    logic [31:0] r = '0;
    if (a == 0) r = {26'b0, m_vtes, 4'b0, m_hven};
    else if (a == 1) r = (m_base & 32'hFFFF_F000) | ({23'b0, v} << (m_vtes ? 3 : 2));
    else if (a == 3 || a == 4)
      for (int l = 0; l < 4; l++) r[8*l] = m_sw[(a-3)*4 + l];
    else if (a >= 5 && a <= 8)
      for (int l = 0; l < 4; l++) r[8*l +: 4] = m_pri[(a-5)*4 + l];
    return r;
  endfunction

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] ep;
    logic [7:0] es;
    for (int i = 0; i < 16; i++) ep[4*i +: 4] = m_pri[i];
    for (int i = 0; i < 8; i++) es[i] = m_sw[i];
    chk("R2", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("R1", "rsp_err", 64'(rsp_err), 64'(e_err));
    chk("R3", "rdata", 64'(rdata), 64'(e_rdata));   // R5 values arrive here too
    chk("R6", "ack_pulse", 64'(ack_pulse), 64'(e_ack));
    chk("R7", "eoi_pulse", 64'(eoi_pulse), 64'(e_eoi));
    chk("R4", "hw_vec_mode", 64'(hw_vec_mode), 64'(m_hven));
    chk("R4", "vec_entry8", 64'(vec_entry8), 64'(m_vtes));
    chk("R8", "sw_pend", 64'(sw_pend), 64'(es));
    chk("R9", "pri_flat", pri_flat, ep);
  endtask

  // one clock: check previous cycle's outputs, then drive and predict
  task automatic step(bit r, bit w, int a, logic [3:0] b, logic [31:0] d, logic [8:0] v);
    bit okk;
    @(negedge clk);
    compare_all();
    req = r; we = w; addr = 6'(a); be = b; wdata = d; cur_vec = v;
    okk = r && legal_lanes(b) && a >= 0 && a <= 8;
    e_valid = r;
    e_err = r && !okk;
    e_rdata = (okk && !w) ? model_read(a, v) : 32'b0;
    e_ack = okk && !w && a == 1;
    e_eoi = okk && w && a == 2;
    if (okk && w) begin
      if (a == 0 && b[0]) begin m_hven = d[0]; m_vtes = d[5]; end
      if (a == 1) begin
        for (int l = 0; l < 4; l++) if (b[l]) m_base[8*l +: 8] = d[8*l +: 8];
        m_base &= 32'hFFFF_F000;
      end
      if (a == 3 || a == 4)
        for (int l = 0; l < 4; l++)
          if (b[l]) begin
            if (d[8*l+1]) m_sw[(a-3)*4 + l] = 1'b1;
            else if (d[8*l]) m_sw[(a-3)*4 + l] = 1'b0;
          end
      if (a >= 5 && a <= 8)
        for (int l = 0; l < 4; l++)
          if (b[l]) m_pri[(a-5)*4 + l] = d[8*l +: 4];
    end
  endtask

  task automatic rd_(int a, logic [3:0] b, logic [8:0] v = 9'h0);
    step(1, 0, a, b, 32'h0, v);
  endtask
  task automatic wr_(int a, logic [3:0] b, logic [31:0] d);
    step(1, 1, a, b, d, 9'h0);
  endtask
  task automatic idle();
    step(0, 0, 0, 4'b0, 32'h0, 9'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_sw[i] = 0;
    for (int i = 0; i < 16; i++) m_pri[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();                          // R10 reset state compared here
    for (int a = 0; a <= 8; a++) rd_(a, 4'b1111);   // R10 reset read-back

    // R4 configuration bits and spare bits
    wr_(0, 4'b1111, 32'hFFFF_FFFF);
    rd_(0, 4'b1111);
    wr_(0, 4'b0010, 32'h0000_0000);  // lane 0 off: no effect
    rd_(0, 4'b0001);

    // R5 / R6 base, shifts and size-independent strobe
    wr_(1, 4'b1111, 32'hABCD_EFFF);
    rd_(1, 4'b0001, 9'h1FF);
    rd_(1, 4'b0110, 9'h155);
    rd_(1, 4'b1111, 9'h001);
    rd_(1, 4'b1000, 9'h1FF);
    wr_(0, 4'b0001, 32'h0000_0001);  // entry size 4 bytes, hw mode kept
    rd_(1, 4'b1100, 9'h1FF);
    rd_(1, 4'b0011, 9'h0AA);
    wr_(0, 4'b0001, 32'h0000_0000);  // software mode, shift 2
    rd_(1, 4'b1111, 9'h1FF);
    wr_(1, 4'b0100, 32'h0012_0000);
    rd_(1, 4'b1111, 9'h0);
    rd_(1, 4'b1111, 9'h0);           // back-to-back acknowledges

    // R7 end-of-interrupt
    wr_(2, 4'b0001, 32'h1);
    wr_(2, 4'b0110, 32'h0);
    wr_(2, 4'b1111, 32'hFFFF_FFFF);
    rd_(2, 4'b1111);

    // R8 software set/clear
    wr_(3, 4'b0110, 32'h0002_0200);
    rd_(3, 4'b1111);
    wr_(4, 4'b1111, 32'h0202_0202);
    wr_(4, 4'b0001, 32'h0000_0001);
    wr_(3, 4'b0010, 32'h0000_0303); // set wins over clear
    wr_(4, 4'b1100, 32'h0101_0000);
    rd_(4, 4'b0001);
    rd_(3, 4'b0100);

    // R9 priorities
    wr_(5, 4'b1111, 32'hFF3C_A51E);
    wr_(6, 4'b0001, 32'h0000_0007);
    wr_(7, 4'b0110, 32'h00F9_F200);
    wr_(8, 4'b1100, 32'hEE44_0000);
    for (int a = 5; a <= 8; a++) rd_(a, 4'b1111);

    // R1 illegal lanes everywhere, R3 unmapped words
    for (int a = 0; a <= 8; a++) begin
      step(1, 1, a, 4'b0101, 32'hFFFF_FFFF, 9'h1FF);
      step(1, 1, a, 4'b0000, 32'hFFFF_FFFF, 9'h1FF);
      step(1, 0, a, 4'b1110, 32'h0, 9'h1FF);
      step(1, 1, a, 4'b1001, 32'h0, 9'h1FF);
    end
    wr_(9, 4'b1111, 32'hFFFF_FFFF);
    rd_(9, 4'b1111);
    wr_(63, 4'b0001, 32'h0000_0023);
    rd_(1, 4'b1111, 9'h0F0);
    for (int a = 0; a <= 8; a++) rd_(a, 4'b1111);
    idle();
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule